// File: doc/BRIEF.md
# Tree Arbiter Issue Select

This block picks which ready instructions in an issue window go to the functional units of one type in a given cycle. Its input is a request vector with one bit per window entry. It gives each unit a one-hot grant vector that names the chosen entry, or an all-zero vector when that unit gets nothing. Priority depends only on position: the requester with the lowest index wins.

Each unit is served by a tree of small arbiter cells with up to four inputs. Request-present signals travel from the leaves up to the root. Grant enables travel back down from the root, and a cell passes a grant to one of its inputs only when its parent has enabled it. The root of a tree is enabled only while its unit is available. When a second unit of the same type exists, a second tree is placed in series behind the first. It sees the request vector with the first tree's grant removed. The window size may be 16, 32 or 64 entries, with one or two units. An optional output register adds one cycle of latency.

Top module: `tree_issue_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `grantVec` and `grantAny` is 0.
- R2: When unit 0 is available (`fuAvail[0]`=1) and at least one request bit is set, bit i of unit 0's grant vector (`grantVec[i]`) is 1 for exactly the lowest index i whose request bit is 1.
- R3: Each unit's grant vector has at most one bit set.
- R4: When `fuAvail[0]`=0, unit 0's grant vector is all zeros whatever the requests are.
- R5: If unit 1 is available, it is granted the lowest-index requester that unit 0 did not take. This is the second-lowest requester when unit 0 granted one, and the lowest requester when unit 0 is unavailable. If unit 1 is not available, its grant vector is zero.
- R6: No window entry is granted to both units in the same cycle.
- R7: `grantAny[u]` is 1 exactly when unit u's grant vector (bits u*WIN to u*WIN+WIN-1 of `grantVec`) is non-zero.
- R8: A grant bit is never set for an entry whose request bit was 0.
- R9: With the output register enabled (the default), the grants follow the inputs by exactly one clock edge. A change of inputs has no effect on the outputs before that edge.
- R10: With no requests, both grant vectors are zero. With a single requester and both units available, only unit 0 receives it, and this holds for the highest entry index as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low asynchronous reset |
| reqVec | input | WIN | Ready bit per window entry |
| fuAvail | input | NUM_FU | Availability per functional unit; enables that unit's tree root |
| grantVec | output | NUM_FU*WIN | One-hot grant per unit, unit u at bits u*WIN upward |
| grantAny | output | NUM_FU | Unit u received a grant this cycle |

## Verification
The block holds no state except the output register, so a wrong internal value shows at the ports on the first clock edge after the stimulus that exposes it. Some faults only show for particular request patterns: a stuck cell enable, a cell that picks the wrong priority, or a missing mask between the two trees. Depending on the fault, the symptom is a grant to a higher-index entry than the lowest requester, a grant that is missing, two bits set in one vector, or the same entry granted to both units. Random request vectors of varying density, together with directed cases at both ends of the window, drive each leaf and each upper-level cell through every position it can select.

// File: rtl/tis_pkg.sv
package tis_pkg;

  localparam int MAX_FU = 2;

  // Strobes from control to datapath: one root enable per tree
  typedef struct packed {
    logic [MAX_FU-1:0] rootEn;
  } sel_strobe_t;

  // Number of nodes present at tree level lvl (level 0 = window entries)
  function automatic int lvlWidth(input int win, input int lvl);
    int w;
    w = win;
    for (int i = 0; i < lvl; i++) w = (w + 3) / 4;
    return w;
  endfunction

  // Number of cell levels until a single root remains
  function automatic int numLevels(input int win);
    int w;
    int n;
    w = win;
    n = 0;
    while (w > 1) begin
      w = (w + 3) / 4;
      n++;
    end
    return n;
  endfunction

  // Start of level lvl inside the flattened node vectors
  function automatic int lvlOffset(input int win, input int lvl);
    int s;
    s = 0;
    for (int i = 0; i < lvl; i++) s += lvlWidth(win, i);
    return s;
  endfunction

endpackage

// File: rtl/arb_cell.sv
module arb_cell #(
  parameter int FAN = 4
) (
  input  logic [FAN-1:0] req,
  input  logic           en,
  output logic           anyOut,
  output logic [FAN-1:0] gnt
);

  logic [FAN-1:0] lowest;

  // isolate the lowest set bit: lower index wins
  assign lowest = req & (~req + FAN'(1));
  assign anyOut = |req;
  assign gnt    = en ? lowest : '0;

endmodule

// File: rtl/arb_tree.sv
module arb_tree
  import tis_pkg::*;
#(
  parameter int WIN = 32
) (
  input  logic [WIN-1:0] req,
  input  logic           rootEn,
  output logic [WIN-1:0] gnt,
  output logic           anyReq
);

  localparam int LEVELS = numLevels(WIN);
  localparam int GNT_W  = lvlOffset(WIN, LEVELS);
  localparam int ANY_W  = GNT_W + 1;

  // anyNode: request-present per node, flowing toward the root
  // gntNode: enable per node, flowing back toward the leaves
  logic [ANY_W-1:0] anyNode;
  logic [GNT_W-1:0] gntNode;

  assign anyNode[WIN-1:0] = req;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
    localparam int IN_W    = lvlWidth(WIN, lvl);
    localparam int CELLS   = lvlWidth(WIN, lvl + 1);
    localparam int FAN     = (IN_W < 4) ? IN_W : 4;
    localparam int IN_OFF  = lvlOffset(WIN, lvl);
    localparam int OUT_OFF = lvlOffset(WIN, lvl + 1);

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
      logic cellEn;
      if (lvl == LEVELS - 1) begin : g_root
        assign cellEn = rootEn;
      end else begin : g_inner
        assign cellEn = gntNode[OUT_OFF + c];
      end

      arb_cell #(.FAN(FAN)) u_cell (
        .req    (anyNode[IN_OFF + FAN*c +: FAN]),
        .en     (cellEn),
        .anyOut (anyNode[OUT_OFF + c]),
        .gnt    (gntNode[IN_OFF + FAN*c +: FAN])
      );
    end
  end

  assign gnt    = gntNode[WIN-1:0];
  assign anyReq = anyNode[ANY_W-1];

endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import tis_pkg::*;
#(
  parameter int NUM_FU = 2
) (
  input  logic [NUM_FU-1:0] fuAvail,
  output sel_strobe_t       strobe
);

  // a tree root is enabled only while its unit can accept work
  always_comb begin
    strobe = '0;
    for (int u = 0; u < NUM_FU; u++) strobe.rootEn[u] = fuAvail[u];
  end

endmodule

// File: rtl/sel_datapath.sv
module sel_datapath
  import tis_pkg::*;
#(
  parameter int WIN     = 32,
  parameter int NUM_FU  = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIN-1:0]        reqVec,
  input  sel_strobe_t           strobe,
  output logic [NUM_FU*WIN-1:0] grantVec,
  output logic [NUM_FU-1:0]     grantAny
);

  localparam int OUT_W = NUM_FU * WIN;

  logic [WIN-1:0]   treeReq [NUM_FU];
  logic [WIN-1:0]   treeGnt [NUM_FU];
  logic [NUM_FU-1:0] treeAny;
  logic [OUT_W-1:0]  gntFlat;
  logic [NUM_FU-1:0] anyFlat;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    if (u == 0) begin : g_first
      assign treeReq[u] = reqVec;
    end else begin : g_chain
      // later tree never sees what an earlier tree already took
      assign treeReq[u] = treeReq[u-1] & ~treeGnt[u-1];
    end

    arb_tree #(.WIN(WIN)) u_tree (
      .req    (treeReq[u]),
      .rootEn (strobe.rootEn[u]),
      .gnt    (treeGnt[u]),
      .anyReq (treeAny[u])
    );

    assign gntFlat[u*WIN +: WIN] = treeGnt[u];
    assign anyFlat[u]            = treeAny[u] & strobe.rootEn[u];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        grantVec <= '0;
        grantAny <= '0;
      end else begin
        grantVec <= gntFlat;
        grantAny <= anyFlat;
      end
    end
  end else begin : g_comb
    assign grantVec = gntFlat;
    assign grantAny = anyFlat;
  end

endmodule

// File: rtl/tree_issue_select.sv
module tree_issue_select
  import tis_pkg::*;
#(
  parameter int WIN     = 32,
  parameter int NUM_FU  = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIN-1:0]        reqVec,
  input  logic [NUM_FU-1:0]     fuAvail,
  output logic [NUM_FU*WIN-1:0] grantVec,
  output logic [NUM_FU-1:0]     grantAny
);

  sel_strobe_t strobe;

  sel_ctrl #(.NUM_FU(NUM_FU)) u_ctrl (
    .fuAvail (fuAvail),
    .strobe  (strobe)
  );

  sel_datapath #(.WIN(WIN), .NUM_FU(NUM_FU), .REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .strobe   (strobe),
    .grantVec (grantVec),
    .grantAny (grantAny)
  );

endmodule

// File: rtl/sel_checker.sv
module sel_checker #(
  parameter int WIN     = 32,
  parameter int NUM_FU  = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [WIN-1:0]        reqVec,
  input logic [NUM_FU-1:0]     fuAvail,
  input logic [NUM_FU*WIN-1:0] grantVec,
  input logic [NUM_FU-1:0]     grantAny
);

  // inputs as seen by the current outputs
  logic [WIN-1:0]    reqSeen;
  logic [NUM_FU-1:0] availSeen;
  logic [WIN-1:0]    g0;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqSeen   <= '0;
        availSeen <= '0;
      end else begin
        reqSeen   <= reqVec;
        availSeen <= fuAvail;
      end
    end
  end else begin : g_now
    assign reqSeen   = reqVec;
    assign availSeen = fuAvail;
  end

  assign g0 = grantVec[WIN-1:0];

  AST_U0_NOT_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    (g0 != '0) |-> (((g0 - WIN'(1)) & reqSeen) == '0)); // R2
  AST_U0_SERVES: assert property (@(posedge clk) disable iff (!rstN)
    (availSeen[0] && (reqSeen != '0)) |-> (g0 != '0)); // R2
  AST_U0_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !availSeen[0] |-> (g0 == '0)); // R4

  for (genvar u = 0; u < NUM_FU; u++) begin : g_u
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantVec[u*WIN +: WIN])); // R3
    AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      grantAny[u] == (grantVec[u*WIN +: WIN] != '0)); // R7
    AST_ONLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
      (grantVec[u*WIN +: WIN] & ~reqSeen) == '0); // R8
  end

  if (NUM_FU > 1) begin : g_pair
    AST_NO_SHARE: assert property (@(posedge clk) disable iff (!rstN)
      (grantVec[WIN-1:0] & grantVec[WIN +: WIN]) == '0); // R6
    AST_U1_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !availSeen[1] |-> (grantVec[WIN +: WIN] == '0)); // R5
  end

endmodule

bind tree_issue_select sel_checker #(.WIN(WIN), .NUM_FU(NUM_FU), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_tree_issue_select.sv
`timescale 1ns/1ps
module sim_tree_issue_select;

  localparam int WIN = 32;
  localparam int NFU = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIN-1:0]   reqVec = '0;
  logic [NFU-1:0]   fuAvail = '0;
  logic [NFU*WIN-1:0] grantVec;
  logic [NFU-1:0]   grantAny;

  int checks = 0;
  int failures = 0;
  logic [2*WIN-1:0] lastExp = '0;

  always #2.5 clk = ~clk;

  tree_issue_select #(.WIN(WIN), .NUM_FU(NFU), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .fuAvail(fuAvail),
    .grantVec(grantVec), .grantAny(grantAny)
  );

  function automatic logic [WIN-1:0] lowBit(input logic [WIN-1:0] v);
    logic [WIN-1:0] r;
    r = '0;
    for (int i = WIN - 1; i >= 0; i--) if (v[i]) begin r = '0; r[i] = 1'b1; end
    return r;
  endfunction

  function automatic logic [2*WIN-1:0] model(input logic [WIN-1:0] rq, input logic [1:0] av);
    logic [WIN-1:0] e0, e1;
    e0 = av[0] ? lowBit(rq) : '0;
    e1 = av[1] ? lowBit(rq & ~e0) : '0;
    return {e1, e0};
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive at a falling edge, verify before and after the next rising edge
  task automatic step(input logic [WIN-1:0] rq, input logic [1:0] av);
    logic [2*WIN-1:0] e;
    e = model(rq, av);
    @(negedge clk);
    reqVec  = rq;
    fuAvail = av;
    #1;
    check("R9 outputs unchanged before edge", grantVec, lastExp);
    @(posedge clk);
    @(negedge clk);
    check("R2 unit0 grant", grantVec[WIN-1:0], e[WIN-1:0]);
    check("R5 unit1 grant", grantVec[2*WIN-1:WIN], e[2*WIN-1:WIN]);
    check("R7 grantAny", grantAny, {|e[2*WIN-1:WIN], |e[WIN-1:0]});
    check("R6 no shared entry", grantVec[WIN-1:0] & grantVec[2*WIN-1:WIN], '0);
    check("R3 unit0 at most one", 64'($countones(grantVec[WIN-1:0]) <= 1), 64'd1);
    check("R3 unit1 at most one", 64'($countones(grantVec[2*WIN-1:WIN]) <= 1), 64'd1);
    check("R8 grants within requests", grantVec & ~{rq, rq}, '0);
    lastExp = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [WIN-1:0] r;
    logic [1:0] a;
    void'($urandom(32'h1d5c_7e01));
    reqVec = '1;
    fuAvail = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 grantVec in reset", grantVec, '0);
    check("R1 grantAny in reset", grantAny, '0);
    rstN = 1'b1;
    reqVec = '0;
    fuAvail = '0;
    #1;
    check("R1 grantVec after release", grantVec, '0);

    // directed corners
    step('0, 2'b11);
    check("R10 no requests", grantVec, '0);
    step(32'h8000_0000, 2'b11);
    check("R10 single top entry to unit0", grantVec, {32'h0, 32'h8000_0000});
    step(32'h0000_0001, 2'b11);
    check("R10 single low entry to unit0", grantVec, {32'h0, 32'h1});
    step('1, 2'b11);
    check("R2 full window lowest two", grantVec, {32'h2, 32'h1});
    step(32'h0010_0400, 2'b10);
    check("R4 unit0 off", grantVec[WIN-1:0], '0);
    check("R5 unit1 takes lowest", grantVec[2*WIN-1:WIN], 32'h400);
    step(32'hFFFF_0000, 2'b00);
    check("R4 both off", grantVec, '0);
    step(32'hC000_0000, 2'b01);
    check("R5 unit1 off", grantVec[2*WIN-1:WIN], '0);
    step(32'h0001_0001, 2'b11);
    check("R2 across subtrees", grantVec, {32'h0001_0000, 32'h1});

    for (int i = 0; i < 400; i++) begin
      r = $urandom();
      case ($urandom_range(0, 3))
        0: r = r & $urandom() & $urandom();
        1: r = r & $urandom();
        2: r = '0 | (WIN'(1) << $urandom_range(0, WIN - 1));
        default: ;
      endcase
      a = 2'($urandom_range(0, 3));
      step(r, a);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule